// File: doc/BRIEF.md
# Grouped-Priority Interrupt Controller

This block collects up to 64 level-sensitive interrupt source lines and presents the winning pending source on two interrupt outputs, a low output and a high output. Each output has a read-only vector register that reports the source number of its current winner. A source can win only when its enable bit in the mask register is set. Sources are gathered into four fixed groups. Each group has its own priority register, which lists up to eight member codes in slots ordered from highest (slot 1) to lowest (slot 8).

Software configures the block over a simple 32-bit word bus with a write strobe and a combinational read path. A control register can promote one source above all others and steer it to either output. A routing register can send slot 1 and slot 2 of each group to the high output. Every other slot always reaches the low output. A host can take the high output as a fast interrupt line and the low output as its ordinary line. It reads the matching vector register to find out which source to service.

Top module: `gpic_top`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0, both outputs are low and both vectors read 0, so every source is masked and every slot routes to the low output.
- R2: Registers sit at word-aligned byte addresses: control 0x00, mask 0x04, routing 0x08, group priority registers 0x10, 0x14, 0x18 and 0x1C (groups 0 to 3), low vector 0x20, high vector 0x24. Writes to the vector registers, to unmapped addresses, or to addresses whose low two bits are not 00 change nothing. Unmapped addresses read 0.
- R3: A source can win only while its mask bit is 1. The mask bit assignments are: sources 1 to 3 on bits 15 to 13, sources 10 to 15 on bits 6 to 1, sources 32 to 36 on bits 31 to 27, and sources 40 to 43 on bits 23 to 20.
- R4: Inputs are level-sensitive and sampled on each rising edge. A change in an input or a register write shows on the outputs and vectors just after the next rising edge, and not before it.
- R5: Each vector register holds the winner in bits 31:26 with all other bits 0. A value of 0 means there is no winner. Each output is high exactly when its vector is non-zero.
- R6: In a group priority register, slots 1 to 3 occupy bits 31:29, 28:26 and 25:23, and slots 4 to 8 occupy bits 14:12, 11:9, 8:6, 5:3 and 2:0. Within a group, a lower-numbered slot wins. Member codes are 0 to 2 for sources 1 to 3, 1 to 6 for sources 10 to 15, 0 to 4 for sources 32 to 36, and 0 to 3 for sources 40 to 43.
- R7: Groups are scanned in the order group 0 (sources 1 to 3), group 1 (10 to 15), group 2 (32 to 36), group 3 (40 to 43). Any slot of an earlier group beats every slot of a later group.
- R8: In the routing register, group g keeps the slot 1 field at bits 4g+3:4g+2 and the slot 2 field at bits 4g+1:4g. A field value of 01 sends that slot to the high output, and any other value sends it to the low output. Slots 3 to 8 always go to the low output.
- R9: The control register names a top source in bits 29:24 and its destination in bits 9:8 (01 = high, otherwise low). The top source, when enabled and pending, beats every other source on that output, and it never wins through its group slot.
- R10: Source numbers without a mask bit, slot codes outside a group's code range, and sources not placed in any slot never win, except that a source in its group's range can still win as the top source.
- R11: The two outputs are arbitrated independently, and a given source can win at most one output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_in | input | 64 | Level interrupt lines, bit n is source n |
| irq_low | output | 1 | Low interrupt output |
| irq_high | output | 1 | High interrupt output |

## Verification
An input change or a register write is due on the outputs one rising edge after it is applied, because the pending lines and the configuration are registered and the arbitration and read paths are combinational. The bench drives every stimulus on a falling edge and samples on the following falling edge, exactly one rising edge later. The latency test also samples just before that edge to show that the old value still holds. Reads need no edge, so each read is sampled a short delay after the address is set within the same low phase.

// File: rtl/gpic_pkg.sv
package gpic_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 6;
    localparam int NUM_SRC  = 64;
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam int NUM_GRP  = 4;
    localparam int NUM_SLOT = 8;
    localparam int CODE_W   = 3;
    localparam int ROUTE_W  = 2;
    localparam int HI_SLOTS = 2;
    localparam int GRP_ROUTE_BITS = ROUTE_W * HI_SLOTS;
    localparam int VEC_LSB  = DATA_W - SRC_W;

    // word indices (byte address / 4)
    localparam int W_CTRL  = 0;
    localparam int W_MASK  = 1;
    localparam int W_ROUTE = 2;
    localparam int W_PRIO0 = 4;
    localparam int W_VLOW  = 8;
    localparam int W_VHIGH = 9;

    // control register fields
    localparam int CTRL_TOP_LSB  = 24;
    localparam int CTRL_DEST_LSB = 8;

    localparam logic [ROUTE_W-1:0] DEST_HIGH = 2'b01;

    typedef logic [SRC_W-1:0]  src_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        src_t top_src;
        logic top_high;
    } ctrl_cfg_t;

    // fixed group membership: first source, first code, member count, mask bit of first member
    localparam int GRP_SRC0 [NUM_GRP] = '{1, 10, 32, 40};
    localparam int GRP_CODE0[NUM_GRP] = '{0, 1, 0, 0};
    localparam int GRP_CNT  [NUM_GRP] = '{3, 6, 5, 4};
    localparam int GRP_MTOP [NUM_GRP] = '{15, 6, 31, 23};

    // least significant bit of priority slot k (k = 0 is slot 1)
    function automatic int slot_lsb(input int k);
        return (k < 3) ? (29 - 3 * k) : (21 - 3 * k);
    endfunction

    function automatic logic code_ok(input int g, input code_t code);
        return (int'(code) >= GRP_CODE0[g]) && (int'(code) < GRP_CODE0[g] + GRP_CNT[g]);
    endfunction

    function automatic src_t code_src(input int g, input code_t code);
        return src_t'(GRP_SRC0[g] + int'(code) - GRP_CODE0[g]);
    endfunction

    function automatic logic src_valid(input int s);
        logic v;
        v = 1'b0;
        for (int g = 0; g < NUM_GRP; g++)
            if (s >= GRP_SRC0[g] && s < GRP_SRC0[g] + GRP_CNT[g]) v = 1'b1;
        return v;
    endfunction

    function automatic int src_bit(input int s);
        int b;
        b = 0;
        for (int g = 0; g < NUM_GRP; g++)
            if (s >= GRP_SRC0[g] && s < GRP_SRC0[g] + GRP_CNT[g]) b = GRP_MTOP[g] - (s - GRP_SRC0[g]);
        return b;
    endfunction

endpackage

// File: rtl/gpic_pend.sv
module gpic_pend
    import gpic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    output logic [NUM_SRC-1:0] pend_q
);

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= src_in;
    end

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> pend_q == $past(src_in)); // R4

endmodule

// File: rtl/gpic_regs.sv
module gpic_regs
    import gpic_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  word_t                         bus_wdata,
    output word_t                         bus_rdata,
    input  src_t                          win_low,
    input  src_t                          win_high,
    output word_t                         mask_q,
    output word_t                         route_q,
    output logic [NUM_GRP-1:0][DATA_W-1:0] prio_q,
    output ctrl_cfg_t                     ctrl_cfg
);

    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              aligned;
    word_t             ctrl_q;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            mask_q  <= '0;
            route_q <= '0;
            prio_q  <= '0;
        end else if (bus_wr && aligned) begin
            if (widx == WIDX_W'(W_CTRL))  ctrl_q  <= bus_wdata;
            if (widx == WIDX_W'(W_MASK))  mask_q  <= bus_wdata;
            if (widx == WIDX_W'(W_ROUTE)) route_q <= bus_wdata;
            for (int g = 0; g < NUM_GRP; g++)
                if (widx == WIDX_W'(W_PRIO0 + g)) prio_q[g] <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (widx == WIDX_W'(W_CTRL))  bus_rdata = ctrl_q;
            if (widx == WIDX_W'(W_MASK))  bus_rdata = mask_q;
            if (widx == WIDX_W'(W_ROUTE)) bus_rdata = route_q;
            if (widx == WIDX_W'(W_VLOW))  bus_rdata = {win_low,  {VEC_LSB{1'b0}}};
            if (widx == WIDX_W'(W_VHIGH)) bus_rdata = {win_high, {VEC_LSB{1'b0}}};
            for (int g = 0; g < NUM_GRP; g++)
                if (widx == WIDX_W'(W_PRIO0 + g)) bus_rdata = prio_q[g];
        end
    end

    assign ctrl_cfg.top_src  = ctrl_q[CTRL_TOP_LSB +: SRC_W];
    assign ctrl_cfg.top_high = (ctrl_q[CTRL_DEST_LSB +: ROUTE_W] == DEST_HIGH);

    AST_VEC_READONLY: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && aligned && (widx == WIDX_W'(W_VLOW) || widx == WIDX_W'(W_VHIGH)))
        |=> (mask_q == $past(mask_q) && ctrl_q == $past(ctrl_q) && route_q == $past(route_q))); // R2

endmodule

// File: rtl/gpic_arb.sv
module gpic_arb
    import gpic_pkg::*;
#(
    parameter logic SEL_HIGH = 1'b0
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_SRC-1:0]             active,
    input  logic [NUM_GRP-1:0][DATA_W-1:0] prio_q,
    input  word_t                          route_q,
    input  ctrl_cfg_t                      ctrl_cfg,
    output src_t                           win
);

    always_comb begin
        logic  found;
        code_t code;
        src_t  cand;
        logic  to_high;
        int    sh;
        win   = '0;
        found = 1'b0;
        // designated top source first
        if ((ctrl_cfg.top_high == SEL_HIGH) && active[ctrl_cfg.top_src]) begin
            win   = ctrl_cfg.top_src;
            found = 1'b1;
        end
        // then groups in fixed order, slots 1..8 inside each group
        for (int g = 0; g < NUM_GRP; g++) begin
            for (int k = 0; k < NUM_SLOT; k++) begin
                code    = prio_q[g][slot_lsb(k) +: CODE_W];
                cand    = code_src(g, code);
                sh      = (k < HI_SLOTS) ? (g * GRP_ROUTE_BITS + (HI_SLOTS - 1 - k) * ROUTE_W) : 0;
                to_high = (k < HI_SLOTS) && (route_q[sh +: ROUTE_W] == DEST_HIGH);
                if (!found && code_ok(g, code) && (cand != ctrl_cfg.top_src)
                    && (to_high == SEL_HIGH) && active[cand]) begin
                    win   = cand;
                    found = 1'b1;
                end
            end
        end
    end

    AST_WIN_LIVE: assert property (@(posedge clk) disable iff (rst) (win != '0) |-> active[win]); // R3
    AST_WIN_ASSIGNED: assert property (@(posedge clk) disable iff (rst) (win != '0) |-> src_valid(int'(win))); // R10

endmodule

// File: rtl/gpic_top.sv
module gpic_top
    import gpic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq_low,
    output logic               irq_high
);

    localparam logic RESERVED_EN = 1'b0;

    logic [NUM_SRC-1:0]             pend_q;
    logic [NUM_SRC-1:0]             active;
    word_t                          mask_q;
    word_t                          route_q;
    logic [NUM_GRP-1:0][DATA_W-1:0] prio_q;
    ctrl_cfg_t                      ctrl_cfg;
    src_t                           win_low;
    src_t                           win_high;

    gpic_pend u_pend (
        .clk    (clk),
        .rst    (rst),
        .src_in (src_in),
        .pend_q (pend_q)
    );

    gpic_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .win_low   (win_low),
        .win_high  (win_high),
        .mask_q    (mask_q),
        .route_q   (route_q),
        .prio_q    (prio_q),
        .ctrl_cfg  (ctrl_cfg)
    );

    // enabled-and-pending per source number; reserved numbers are tied off
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_act
        if (src_valid(s)) begin : g_used
            assign active[s] = pend_q[s] & mask_q[src_bit(s)];
        end else begin : g_resv
            assign active[s] = pend_q[s] & RESERVED_EN;
        end
    end

    gpic_arb #(.SEL_HIGH(1'b0)) u_arb_low (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .prio_q   (prio_q),
        .route_q  (route_q),
        .ctrl_cfg (ctrl_cfg),
        .win      (win_low)
    );

    gpic_arb #(.SEL_HIGH(1'b1)) u_arb_high (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .prio_q   (prio_q),
        .route_q  (route_q),
        .ctrl_cfg (ctrl_cfg),
        .win      (win_high)
    );

    assign irq_low  = (win_low  != '0);
    assign irq_high = (win_high != '0);

    AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (rst) (irq_low && irq_high) |-> (win_low != win_high)); // R11
    AST_TOP_WINS: assert property (@(posedge clk) disable iff (rst) (ctrl_cfg.top_high && active[ctrl_cfg.top_src]) |-> (win_high == ctrl_cfg.top_src)); // R9

endmodule

// File: tb/tb_gpic_top.sv
`timescale 1ns/1ps
module tb_gpic_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_in = '0;
    logic        irq_low, irq_high;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpic_top dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .irq_low(irq_low), .irq_high(irq_high)
    );

    typedef struct packed {
        logic [63:0] src;
        logic [31:0] mask;
        logic [5:0]  exp_low;
        logic [5:0]  exp_high;
        logic [3:0]  req;
    } row_t;

    localparam logic [31:0] FULL_MASK = 32'hF8F0_E07E;
    localparam int NROWS = 15;

    // configuration used by the table:
    // g0: 3,1,2 ; g1: 15,10,11,12,13,14 ; g2: 32..36 ; g3: 43,42,41,40
    // routing: src15 (g1 slot1) high, src33 (g2 slot2) high, g3 slot1 field 10 (low)
    // control: top source 12, destination high
    localparam row_t TBL [NROWS] = '{
        '{64'h0,                   FULL_MASK,    6'd0,  6'd0,  4'd5},
        '{64'h4,                   FULL_MASK,    6'd2,  6'd0,  4'd6},
        '{64'h6,                   FULL_MASK,    6'd1,  6'd0,  4'd6},
        '{64'hA,                   FULL_MASK,    6'd3,  6'd0,  4'd6},
        '{64'h8000,                FULL_MASK,    6'd0,  6'd15, 4'd8},
        '{64'hC000,                FULL_MASK,    6'd14, 6'd15, 4'd8},
        '{64'h9000,                FULL_MASK,    6'd0,  6'd12, 4'd9},
        '{64'h9000,                32'hF8F0_E06E, 6'd0, 6'd15, 4'd3},
        '{64'h0000_0802_0000_0000, FULL_MASK,    6'd43, 6'd33, 4'd11},
        '{64'h0000_0010_0000_0800, FULL_MASK,    6'd11, 6'd0,  4'd7},
        '{64'h0000_0300_0000_0000, FULL_MASK,    6'd41, 6'd0,  4'd6},
        '{64'h8000_0000_0010_0021, FULL_MASK,    6'd0,  6'd0,  4'd10},
        '{64'h0000_0005_0000_0000, 32'h78F0_E07E, 6'd34, 6'd0, 4'd3},
        '{64'hFFFF_FFFF_FFFF_FFFF, FULL_MASK,    6'd3,  6'd12, 4'd9},
        '{64'h0000_0010_0000_0004, 32'hF8F0_007E, 6'd36, 6'd0, 4'd7}
    };

    function automatic string rname(input logic [3:0] r);
        case (r)
            4'd3:  return "R3";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic check_out(input string req, input logic [5:0] el, input logic [5:0] eh);
        logic [31:0] v;
        rd(6'h20, v);
        check(req, v, {el, 26'b0});
        rd(6'h24, v);
        check(req, v, {eh, 26'b0});
        check(req, {31'b0, irq_low},  {31'b0, el != 6'd0});
        check(req, {31'b0, irq_high}, {31'b0, eh != 6'd0});
    endtask

    task automatic configure();
        wr(6'h10, 32'h4080_7FFF);
        wr(6'h14, 32'hC500_3940);
        wr(6'h18, 32'h0500_39FF);
        wr(6'h1C, 32'h6880_0FFF);
        wr(6'h08, 32'h0000_8140);
        wr(6'h00, 32'h0C00_0100);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 10; a++) begin
            rd(6'(a * 4), v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 reset outputs", {30'b0, irq_low, irq_high}, 32'h0);

        // R1: masked after reset even with all inputs driven
        src_in = '1;
        @(negedge clk);
        check_out("R1 all masked", 6'd0, 6'd0);
        src_in = '0;

        // R2: register readback
        configure();
        rd(6'h10, v); check("R2 prio g0 readback", v, 32'h4080_7FFF);
        rd(6'h1C, v); check("R2 prio g3 readback", v, 32'h6880_0FFF);
        rd(6'h08, v); check("R2 route readback",   v, 32'h0000_8140);
        rd(6'h00, v); check("R2 ctrl readback",    v, 32'h0C00_0100);
        rd(6'h0C, v); check("R2 unmapped reads 0", v, 32'h0);
        wr(6'h01, 32'hFFFF_FFFF);
        rd(6'h00, v); check("R2 misaligned write ignored", v, 32'h0C00_0100);
        wr(6'h04, FULL_MASK);
        rd(6'h04, v); check("R2 mask readback", v, FULL_MASK);

        // table of vectors: mask write then input pattern, checked one edge later
        for (int i = 0; i < NROWS; i++) begin
            wr(6'h04, TBL[i].mask);
            src_in = TBL[i].src;
            @(negedge clk);
            check_out(rname(TBL[i].req), TBL[i].exp_low, TBL[i].exp_high);
        end

        // R2: vector register is not writable
        wr(6'h04, FULL_MASK);
        src_in = 64'h8;
        @(negedge clk);
        bus_addr = 6'h20; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(6'h20, v); check("R2 vector write ignored", v, {6'd3, 26'b0});
        rd(6'h04, v); check("R2 vector write leaves mask", v, FULL_MASK);

        // R4: latency of exactly one edge, level release
        src_in = '0;
        @(negedge clk);
        check("R4 released", {31'b0, irq_low}, 32'h0);
        src_in = 64'h4;
        #1;
        check("R4 not before edge", {31'b0, irq_low}, 32'h0);
        @(negedge clk);
        check("R4 after one edge", {31'b0, irq_low}, 32'h1);
        repeat (3) @(negedge clk);
        check("R4 held level stays pending", {31'b0, irq_low}, 32'h1);
        src_in = '0;
        #1;
        check("R4 still set before edge", {31'b0, irq_low}, 32'h1);
        @(negedge clk);
        check("R4 drop after one edge", {31'b0, irq_low}, 32'h0);

        // R9: top source routed low
        wr(6'h00, 32'h0C00_0000);
        src_in = 64'h9000;
        @(negedge clk);
        check_out("R9 top source on low", 6'd12, 6'd15);

        // R9: top source excluded from its group slot
        wr(6'h00, 32'h0F00_0000);
        src_in = 64'h8000;
        @(negedge clk);
        check_out("R9 top source skips group route", 6'd15, 6'd0);

        // R8: field value 11 is not high
        wr(6'h00, 32'h0);
        wr(6'h08, 32'h0000_80C0);
        @(negedge clk);
        check_out("R8 field 11 goes low", 6'd15, 6'd0);

        // R10: code outside range in slot 1, source 12 placed nowhere
        wr(6'h14, 32'h0000_0000);
        src_in = 64'h1000;
        @(negedge clk);
        check_out("R10 unplaced source", 6'd0, 6'd0);

        // R1: reset mid-run clears everything
        src_in = 64'h8;
        wr(6'h10, 32'h4080_7FFF);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(6'h04, v); check("R1 mask cleared", v, 32'h0);
        rd(6'h10, v); check("R1 prio cleared", v, 32'h0);
        check_out("R1 outputs after reset", 6'd0, 6'd0);

        finish_run();
    end

endmodule